// File: doc/BRIEF.md
# Debug Trigger Chaining Unit

This block turns raw per-trigger match results into final debug trap decisions. It holds ten hardware triggers grouped into five fixed pairs, where trigger 2i is paired with trigger 2i+1. Each pair is bound to one combination of access kinds. Pair 0 is fetch with fetch, pair 1 is store with store, pair 2 is load with load, pair 3 is fetch with store, and pair 4 is fetch with load. The address comparators sit outside the block. Every cycle they deliver hit bits for fetch, store and load accesses. The block gates those hits with a per-trigger enable, applies chaining within each pair and resolves the timing of the trap.

Trigger configuration is written through a valid-qualified port. Fetch triggers and memory triggers have separate address spaces. The stored compare values, match types and select bits are driven back out so the external comparators can use them. There are two outputs that request a trap: one for a trap before the matching instruction and one for a trap after it. Alongside them the block reports the index and the action bit of the trigger that won priority.

Top module: `dbg_trig_chain`

## Requirements
- R1: After reset every enable, chain bit, timing bit, action bit, select bit, match type and compare value is zero. While reset is held, and after it until triggers are enabled, no trap output rises, even with every hit input high.
- R2: A configuration write with `cfg_mem_i`=0 addresses the fetch triggers through `cfg_addr_i[1:0]`: 0→0, 1→1, 2→6, 3→8. A write with `cfg_mem_i`=1 addresses the memory triggers through `cfg_addr_i`: 0→2, 1→3, 2→4, 3→5, 4→7, 5→9. Memory addresses 6 and 7 change nothing. A write is visible on `tdata_o`, `mtype_o` and `sel_o` in the cycle after the clock edge that captures it.
- R3: Hit bits map to triggers as follows. `fetch_hit_i[0..3]` drive triggers 0, 1, 6 and 8. `store_hit_i[0..2]` drive triggers 2, 3 and 7. `load_hit_i[0..2]` drive triggers 4, 5 and 9.
- R4: `en_we_i` loads `en_i` into the enable vector, where bit t belongs to trigger t. A disabled trigger contributes no hit, so a chained pair that contains a disabled trigger cannot fire.
- R5: In an unchained pair each trigger fires on its own enabled hit. A timing bit of 0 gives a before-trap and a timing bit of 1 gives an after-trap.
- R6: The stored chain bit of the even trigger 2i chains pair i. A chained pair fires only when both triggers have an enabled hit in the same cycle, and it is then reported as index 2i.
- R7: A chained pair whose two timing bits differ never fires, even when both triggers hit.
- R8: A chain bit written to a trigger of the store/store pair (triggers 2 and 3) is stored as 0.
- R9: A chain bit written to a load trigger (4, 5 or 9) together with select bit 1 (compare on data) is stored as 0.
- R10: `fire_before_o` is high when any before-trap fires. `fire_after_o` is high only when an after-trap fires and no before-trap does. `fire_idx_o` gives the lowest-numbered trigger in the winning class, and all three outputs are 0 when nothing fires.
- R11: `fire_action_o` carries the action bit of the trigger reported on `fire_idx_o`, and is 0 when nothing fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write valid |
| cfg_mem_i | input | 1 | 0: fetch trigger space, 1: memory trigger space |
| cfg_addr_i | input | 3 | Trigger address within the selected space |
| cfg_mtype_i | input | 2 | Match type |
| cfg_sel_i | input | 1 | Select bit (1 = compare on data) |
| cfg_timing_i | input | 1 | 0: trap before, 1: trap after |
| cfg_action_i | input | 1 | Action bit |
| cfg_chain_i | input | 1 | Requested chain bit |
| cfg_tdata_i | input | TDATA_W | Compare value |
| en_we_i | input | 1 | Enable vector write |
| en_i | input | 10 | Enable vector value |
| fetch_hit_i | input | 4 | Fetch comparator hits |
| store_hit_i | input | 3 | Store comparator hits |
| load_hit_i | input | 3 | Load comparator hits |
| tdata_o | output | 10×TDATA_W | Stored compare values |
| mtype_o | output | 10×2 | Stored match types |
| sel_o | output | 10 | Stored select bits |
| fire_before_o | output | 1 | Trap before the instruction |
| fire_after_o | output | 1 | Trap after the instruction |
| fire_idx_o | output | 4 | Index of the reported trigger |
| fire_action_o | output | 1 | Action bit of the reported trigger |

## Verification
The bench builds the block with the default `TDATA_W` of 64. This makes every stored compare value a full-width, distinct pattern, so a mis-addressed write shows up as a wrong word on `tdata_o`. The fixed ten-trigger map lets a single configuration cover several cases at once: an unchained fetch pair with mixed timing, a properly chained pair, a chained pair with mismatched timing, and the two illegal-chain cases. The vector table then runs before/after priority across pairs against that one setup.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int NUM_PAIRS = 5;
  localparam int NUM_TRIG  = 2 * NUM_PAIRS;
  localparam int IDX_W     = $clog2(NUM_TRIG);
  localparam int N_FETCH   = 4;
  localparam int N_STORE   = 3;
  localparam int N_LOAD    = 3;
  localparam int ADDR_W    = 3;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_STORE = 2'd1,
    ACC_LOAD  = 2'd2
  } acc_e;

  typedef struct packed {
    logic [1:0] mtype;
    logic       sel;
    logic       timing;
    logic       action;
    logic       chain;
  } trig_ctl_t;

  // Fixed access kind per trigger; pairs are (F,F) (S,S) (L,L) (F,S) (F,L)
  function automatic acc_e kind_of(input int t);
    case (t)
      0, 1, 6, 8: return ACC_FETCH;
      2, 3, 7:    return ACC_STORE;
      default:    return ACC_LOAD;
    endcase
  endfunction

  // Position of a trigger inside the hit vector of its access kind
  function automatic int slot_of(input int t);
    case (t)
      0, 2, 4: return 0;
      1, 3, 5: return 1;
      6, 7, 9: return 2;
      default: return 3;
    endcase
  endfunction

  // Write address inside the fetch or memory space
  function automatic int waddr_of(input int t);
    case (t)
      0, 2:    return 0;
      1, 3:    return 1;
      4, 6:    return 2;
      5, 8:    return 3;
      7:       return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/dbg_trig_cfg.sv
module dbg_trig_cfg
  import dbg_trig_pkg::*;
#(
  parameter int TDATA_W = 64
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic                                mem_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  trig_ctl_t                           ctl_i,
  input  logic [TDATA_W-1:0]                  tdata_i,
  input  logic                                en_we_i,
  input  logic [NUM_TRIG-1:0]                 en_i,
  output trig_ctl_t [NUM_TRIG-1:0]            ctl_o,
  output logic [NUM_TRIG-1:0][TDATA_W-1:0]    tdata_o,
  output logic [NUM_TRIG-1:0]                 en_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= '0;
    else if (en_we_i) en_o <= en_i;
  end

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    localparam acc_e            KIND       = kind_of(t);
    localparam bit              IS_MEM     = (KIND != ACC_FETCH);
    localparam logic [ADDR_W-1:0] WADDR    = ADDR_W'(waddr_of(t));
    localparam bit              STORE_PAIR = (KIND == ACC_STORE) && (kind_of(t ^ 1) == ACC_STORE);
    localparam bit              IS_LOAD    = (KIND == ACC_LOAD);

    logic      addr_hit;
    logic      chain_ok;
    trig_ctl_t ctl_d;

    if (IS_MEM) begin : g_mem
      assign addr_hit = mem_i && (addr_i == WADDR);
    end else begin : g_fetch
      assign addr_hit = !mem_i && (addr_i[1:0] == WADDR[1:0]);
    end

    // illegal chains are dropped at write time
    assign chain_ok = ctl_i.chain && !STORE_PAIR && !(IS_LOAD && ctl_i.sel);

    always_comb begin
      ctl_d       = ctl_i;
      ctl_d.chain = chain_ok;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_o[t]   <= '0;
        tdata_o[t] <= '0;
      end else if (we_i && addr_hit) begin
        ctl_o[t]   <= ctl_d;
        tdata_o[t] <= tdata_i;
      end
    end
  end

endmodule

// File: rtl/dbg_trig_pair.sv
module dbg_trig_pair (
  input  logic [1:0] hit_i,
  input  logic       chain_i,
  input  logic [1:0] timing_i,
  output logic [1:0] fire_o
);
  logic both;

  assign both   = (&hit_i) && (timing_i[0] == timing_i[1]);
  assign fire_o = chain_i ? {both, both} : hit_i;
endmodule

// File: rtl/dbg_trig_prio.sv
module dbg_trig_prio
  import dbg_trig_pkg::*;
(
  input  logic [NUM_TRIG-1:0] fire_i,
  input  logic [NUM_TRIG-1:0] timing_i,
  input  logic [NUM_TRIG-1:0] action_i,
  output logic                before_o,
  output logic                after_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic                action_o
);
  logic [NUM_TRIG-1:0] fb, fa, win;

  assign fb       = fire_i & ~timing_i;
  assign fa       = fire_i & timing_i;
  assign before_o = |fb;
  assign after_o  = (|fa) && !before_o;
  assign win      = before_o ? fb : fa;

  always_comb begin
    idx_o = '0;
    for (int k = NUM_TRIG - 1; k >= 0; k--) begin
      if (win[k]) idx_o = IDX_W'(k);
    end
  end

  assign action_o = (|win) && action_i[idx_o];
endmodule

// File: rtl/dbg_trig_chain.sv
module dbg_trig_chain
  import dbg_trig_pkg::*;
#(
  parameter int TDATA_W = 64
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              cfg_we_i,
  input  logic                              cfg_mem_i,
  input  logic [ADDR_W-1:0]                 cfg_addr_i,
  input  logic [1:0]                        cfg_mtype_i,
  input  logic                              cfg_sel_i,
  input  logic                              cfg_timing_i,
  input  logic                              cfg_action_i,
  input  logic                              cfg_chain_i,
  input  logic [TDATA_W-1:0]                cfg_tdata_i,
  input  logic                              en_we_i,
  input  logic [NUM_TRIG-1:0]               en_i,
  input  logic [N_FETCH-1:0]                fetch_hit_i,
  input  logic [N_STORE-1:0]                store_hit_i,
  input  logic [N_LOAD-1:0]                 load_hit_i,
  output logic [NUM_TRIG-1:0][TDATA_W-1:0]  tdata_o,
  output logic [NUM_TRIG-1:0][1:0]          mtype_o,
  output logic [NUM_TRIG-1:0]               sel_o,
  output logic                              fire_before_o,
  output logic                              fire_after_o,
  output logic [IDX_W-1:0]                  fire_idx_o,
  output logic                              fire_action_o
);

  trig_ctl_t                 ctl_in;
  trig_ctl_t [NUM_TRIG-1:0]  ctl_q;
  logic [NUM_TRIG-1:0]       en_q, chain_q, timing_q, sel_q, action_q;
  logic [NUM_TRIG-1:0]       raw_hit, hit_v, fire_v;

  always_comb begin
    ctl_in.mtype  = cfg_mtype_i;
    ctl_in.sel    = cfg_sel_i;
    ctl_in.timing = cfg_timing_i;
    ctl_in.action = cfg_action_i;
    ctl_in.chain  = cfg_chain_i;
  end

  dbg_trig_cfg #(.TDATA_W(TDATA_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .mem_i   (cfg_mem_i),
    .addr_i  (cfg_addr_i),
    .ctl_i   (ctl_in),
    .tdata_i (cfg_tdata_i),
    .en_we_i (en_we_i),
    .en_i    (en_i),
    .ctl_o   (ctl_q),
    .tdata_o (tdata_o),
    .en_o    (en_q)
  );

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_map
    localparam acc_e KIND = kind_of(t);
    localparam int   SLOT = slot_of(t);

    if (KIND == ACC_FETCH) begin : g_f
      assign raw_hit[t] = fetch_hit_i[SLOT];
    end else if (KIND == ACC_STORE) begin : g_s
      assign raw_hit[t] = store_hit_i[SLOT];
    end else begin : g_l
      assign raw_hit[t] = load_hit_i[SLOT];
    end

    assign chain_q[t]  = ctl_q[t].chain;
    assign timing_q[t] = ctl_q[t].timing;
    assign sel_q[t]    = ctl_q[t].sel;
    assign action_q[t] = ctl_q[t].action;
    assign mtype_o[t]  = ctl_q[t].mtype;
  end

  assign sel_o = sel_q;
  assign hit_v = raw_hit & en_q;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    dbg_trig_pair u_pair (
      .hit_i    (hit_v[2*p+1 -: 2]),
      .chain_i  (chain_q[2*p]),
      .timing_i (timing_q[2*p+1 -: 2]),
      .fire_o   (fire_v[2*p+1 -: 2])
    );
  end

  dbg_trig_prio u_prio (
    .fire_i   (fire_v),
    .timing_i (timing_q),
    .action_i (action_q),
    .before_o (fire_before_o),
    .after_o  (fire_after_o),
    .idx_o    (fire_idx_o),
    .action_o (fire_action_o)
  );

endmodule

// File: rtl/dbg_trig_chain_chk.sv
module dbg_trig_chain_chk
  import dbg_trig_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                fire_before_o,
  input logic                fire_after_o,
  input logic [IDX_W-1:0]    fire_idx_o,
  input logic [NUM_TRIG-1:0] en_q,
  input logic [NUM_TRIG-1:0] chain_q,
  input logic [NUM_TRIG-1:0] timing_q,
  input logic [NUM_TRIG-1:0] sel_q,
  input logic [NUM_TRIG-1:0] hit_v
);
  logic any_fire;
  assign any_fire = fire_before_o || fire_after_o;

  // R10
  excl_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fire_before_o && fire_after_o));

  // R4
  fired_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_fire |-> en_q[fire_idx_o] && hit_v[fire_idx_o]);

  // R8
  store_pair_unchained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chain_q[2] && !chain_q[3]);

  // R9
  load_data_unchained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_q[4] && chain_q[4]) && !(sel_q[5] && chain_q[5]) && !(sel_q[9] && chain_q[9]));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    // R6
    chain_both_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (any_fire && chain_q[2*p] && fire_idx_o == IDX_W'(2*p)) |-> hit_v[2*p] && hit_v[2*p+1]);
    // R7
    chain_timing_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (any_fire && chain_q[2*p] && fire_idx_o == IDX_W'(2*p)) |-> timing_q[2*p] == timing_q[2*p+1]);
  end
endmodule

bind dbg_trig_chain dbg_trig_chain_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fire_before_o (fire_before_o),
  .fire_after_o  (fire_after_o),
  .fire_idx_o    (fire_idx_o),
  .en_q          (en_q),
  .chain_q       (chain_q),
  .timing_q      (timing_q),
  .sel_q         (sel_q),
  .hit_v         (hit_v)
);

// File: tb/dbg_trig_chain_test.sv
module dbg_trig_chain_test;
  localparam int TW = 64;
  localparam int NT = 10;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we = 1'b0, cfg_mem = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [1:0] cfg_mtype = '0;
  logic cfg_sel = 1'b0, cfg_timing = 1'b0, cfg_action = 1'b0, cfg_chain = 1'b0;
  logic [TW-1:0] cfg_tdata = '0;
  logic en_we = 1'b0;
  logic [NT-1:0] en = '0;
  logic [3:0] fhit = '0;
  logic [2:0] shit = '0, lhit = '0;
  logic [NT-1:0][TW-1:0] tdata_o;
  logic [NT-1:0][1:0] mtype_o;
  logic [NT-1:0] sel_o;
  logic fb, fa, fact;
  logic [3:0] fidx;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dbg_trig_chain #(.TDATA_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_mem_i(cfg_mem), .cfg_addr_i(cfg_addr),
    .cfg_mtype_i(cfg_mtype), .cfg_sel_i(cfg_sel), .cfg_timing_i(cfg_timing),
    .cfg_action_i(cfg_action), .cfg_chain_i(cfg_chain), .cfg_tdata_i(cfg_tdata),
    .en_we_i(en_we), .en_i(en),
    .fetch_hit_i(fhit), .store_hit_i(shit), .load_hit_i(lhit),
    .tdata_o(tdata_o), .mtype_o(mtype_o), .sel_o(sel_o),
    .fire_before_o(fb), .fire_after_o(fa), .fire_idx_o(fidx), .fire_action_o(fact)
  );

  // {fetch[3:0] (t0,t1,t6,t8), store[2:0] (t2,t3,t7), load[2:0] (t4,t5,t9), before, after, idx[3:0], action}
  localparam logic [16:0] VECS [NV] = '{
    {4'b0000, 3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 1'b0}, // idle
    {4'b0001, 3'b000, 3'b000, 1'b1, 1'b0, 4'd0, 1'b1}, // R5 R11 t0 before
    {4'b0010, 3'b000, 3'b000, 1'b0, 1'b1, 4'd1, 1'b0}, // R5 t1 after
    {4'b0011, 3'b000, 3'b000, 1'b1, 1'b0, 4'd0, 1'b1}, // R10 before wins
    {4'b0100, 3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 1'b0}, // R6 t6 alone
    {4'b0100, 3'b100, 3'b000, 1'b1, 1'b0, 4'd6, 1'b0}, // R6 t6+t7
    {4'b0000, 3'b100, 3'b000, 1'b0, 1'b0, 4'd0, 1'b0}, // R6 t7 alone
    {4'b1000, 3'b000, 3'b100, 1'b0, 1'b0, 4'd0, 1'b0}, // R7 t8+t9 mismatch
    {4'b1000, 3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 1'b0}, // R7 t8 alone
    {4'b0000, 3'b001, 3'b000, 1'b1, 1'b0, 4'd2, 1'b0}, // R8 t2 unchained
    {4'b0000, 3'b010, 3'b000, 1'b1, 1'b0, 4'd3, 1'b0}, // R3 t3
    {4'b0000, 3'b000, 3'b001, 1'b0, 1'b1, 4'd4, 1'b0}, // R9 t4 unchained after
    {4'b0000, 3'b000, 3'b011, 1'b1, 1'b0, 4'd5, 1'b1}, // R10 R11 t5 before
    {4'b0000, 3'b010, 3'b001, 1'b1, 1'b0, 4'd3, 1'b0}, // R10 t3 over t4
    {4'b0010, 3'b000, 3'b001, 1'b0, 1'b1, 4'd1, 1'b0}  // R10 lowest after
  };

  task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] tval(input int t);
    return {32'hC0FFEE00, 28'h0, 4'(t)};
  endfunction

  task automatic wcfg(input logic mem, input logic [2:0] a, input logic sel, input logic tim,
                      input logic act, input logic ch, input logic [TW-1:0] td);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_mem = mem; cfg_addr = a; cfg_mtype = a[1:0];
    cfg_sel = sel; cfg_timing = tim; cfg_action = act; cfg_chain = ch; cfg_tdata = td;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wen(input logic [NT-1:0] v);
    @(posedge clk); #1;
    en_we = 1'b1; en = v;
    @(posedge clk); #1;
    en_we = 1'b0;
  endtask

  task automatic drive_hits(input logic [3:0] f, input logic [2:0] s, input logic [2:0] l);
    fhit = f; shit = s; lhit = l;
    #3;
  endtask

  initial begin : watchdog
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    logic [TW-1:0] snap [NT];
    logic [6:0] exp7;
    // R1 during reset, all hits high
    drive_hits(4'hF, 3'h7, 3'h7);
    check("R1 in reset", {fb, fa, fidx, fact}, '0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset no fire", {fb, fa, fidx, fact}, '0);
    check("R1 tdata cleared", tdata_o[9] | tdata_o[0] | tdata_o[5], '0);
    drive_hits(4'h0, 3'h0, 3'h0);

    // configuration: fetch space
    wcfg(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, tval(0)); // t0 before, action 1
    wcfg(1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, tval(1)); // t1 after
    wcfg(1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, tval(6)); // t6 chain pair3
    wcfg(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, tval(8)); // t8 chain pair4
    // memory space
    wcfg(1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, tval(2)); // t2 chain forced off (R8)
    wcfg(1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, tval(3));
    wcfg(1'b1, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1, tval(4)); // t4 data compare, chain forced off (R9)
    wcfg(1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, tval(5));
    wcfg(1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, tval(7));
    wcfg(1'b1, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, tval(9)); // t9 after -> mismatch with t8

    // R2 address map
    for (int t = 0; t < NT; t++) check($sformatf("R2 tdata t%0d", t), tdata_o[t], tval(t));
    check("R2 sel t4", {63'b0, sel_o[4]}, 64'd1);
    check("R2 mtype t7", {62'b0, mtype_o[7]}, 64'd0);
    for (int t = 0; t < NT; t++) snap[t] = tdata_o[t];
    wcfg(1'b1, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, '1);
    wcfg(1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, '1);
    begin
      logic same;
      same = 1'b1;
      for (int t = 0; t < NT; t++) if (tdata_o[t] !== snap[t]) same = 1'b0;
      check("R2 unused mem address ignored", {63'b0, same}, 64'd1);
    end
    check("R4 no fire before enable", {fb, fa, fidx, fact}, '0);

    wen('1);
    for (int v = 0; v < NV; v++) begin
      drive_hits(VECS[v][16:13], VECS[v][12:10], VECS[v][9:7]);
      exp7 = VECS[v][6:0];
      check($sformatf("vector %0d (R3 R5 R6 R7 R8 R9 R10 R11)", v), {fb, fa, fidx, fact}, exp7);
      @(posedge clk); #1;
    end
    drive_hits(4'h0, 3'h0, 3'h0);

    // R4 disable t0: only t1 after remains
    wen(10'h3FE);
    drive_hits(4'b0011, 3'b000, 3'b000);
    check("R4 disabled t0", {fb, fa, fidx, fact}, {1'b0, 1'b1, 4'd1, 1'b0});
    drive_hits(4'h0, 3'h0, 3'h0);
    // R4 disabled t7 breaks chained pair3
    wen(10'h37F);
    drive_hits(4'b0100, 3'b100, 3'b000);
    check("R4 chain broken by disable", {fb, fa, fidx, fact}, '0);

    // R1 reset mid-run
    drive_hits(4'hF, 3'h7, 3'h7);
    rst_ni = 1'b0;
    #2;
    check("R1 reset clears fire", {fb, fa, fidx, fact}, '0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    check("R1 reset clears config", tdata_o[3], '0);
    check("R1 no fire after reset", {fb, fa, fidx, fact}, '0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule